// File: doc/BRIEF.md
# Event-Matched Delayed Trigger Generator

This block sits behind an event-link receiver. The receiver supplies a clock recovered from the link and a stream of decoded 8-bit event codes, each marked by a valid strobe. The block drives a bank of trigger outputs. Each output is programmed with its own event code, delay and pulse width. When its code arrives, the output produces a single pulse after the programmed number of clock cycles.

One programmable code marks the start of a machine cycle. When that code arrives, a free-running divider is forced back to zero, so the clock derived from the divider keeps the same phase relative to every cycle. A 256-entry mask chooses which codes set sticky per-code interrupt flags. A summary request stays high while any flag is set, and the host clears flags by writing ones to a clear vector.

All configuration arrives as plain input vectors. The host logic that owns the registers holds them steady while a channel is active.

Top module: `evtrig_gen`

## Requirements
- R1: There are NCH (default 8) channels. Each has its own enable, 8-bit match code, 16-bit delay and 8-bit width. A channel that has not matched since it was last enabled keeps its output low, whatever the other channels do.
- R2: An event is sampled at clock edge E when `evt_valid` is high, the code equals the channel's match code and the channel is enabled. The channel output then reads high after edge E+D and low again after edge E+D+W, where D is the delay and W is the width. With D=0 the output is high in the cycle right after edge E.
- R3: A channel with width 0 never raises its output.
- R4: A new match while a channel is counting its delay or driving its pulse restarts the timing of R2 from the new event.
- R5: A channel whose enable is low never drives its output high. Dropping the enable aborts any pending delay or pulse, and the output is low after that edge.
- R6: The divider count goes up by one on each clock edge and wraps modulo 2^DIV_W. `div_clk` is the most significant bit of the count.
- R7: A valid event whose code equals `sync_code` makes the divider count read 0 after the edge at which the event is sampled.
- R8: A valid event with code c sets interrupt flag c at its edge when `irq_mask[c]` is 1. Flags stay set until cleared.
- R9: A 1 at bit c of `irq_clr` clears flag c at the next edge. If the same edge also sets flag c, the set wins.
- R10: `irq_req` is high exactly when at least one interrupt flag is set.
- R11: After reset all trigger outputs are low, the divider count is 0 and all flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock recovered from the event link |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A decoded event is present this cycle |
| evt_code | input | 8 | Decoded event code |
| ch_enable | input | NCH | Per-channel enable |
| ch_code | input | NCH*8 | Match code, channel k at bits [8k+7:8k] |
| ch_delay | input | NCH*16 | Delay in cycles, channel k at bits [16k+15:16k] |
| ch_width | input | NCH*8 | Pulse width in cycles, channel k at bits [8k+7:8k] |
| sync_code | input | 8 | Start-of-cycle event code |
| irq_mask | input | 256 | Bit c lets code c set flag c |
| irq_clr | input | 256 | Bit c clears flag c (write-one-to-clear) |
| trig_out | output | NCH | Trigger outputs |
| div_count | output | DIV_W | Phase divider count |
| div_clk | output | 1 | Derived clock, MSB of the divider |
| irq_flags | output | 256 | Sticky per-code interrupt flags |
| irq_req | output | 1 | OR of all flags |

## Verification
Every registered result shows up one edge after the edge that samples its cause. A trigger rises D edges after the matching event, or right after that edge when D is 0. The divider reads 0, and a flag is set or cleared, one edge after the event or the clear. `irq_req` follows the flags in the same cycle. The bench drives inputs at the falling edge. It counts rising edges and, after each one, records which edge each channel last matched. At the next falling edge it compares every output against closed-form expectations computed from those edge counts, so each result is sampled in the cycle it becomes due.

// File: rtl/evtrig_pkg.sv
package evtrig_pkg;
  parameter int EV_CODE_W = 8;
  parameter int EV_NCODE  = 1 << EV_CODE_W;

  typedef enum logic [1:0] {CH_IDLE, CH_DELAY, CH_PULSE} ch_state_e;

  function automatic logic [EV_NCODE-1:0] code_onehot(input logic [EV_CODE_W-1:0] code);
    logic [EV_NCODE-1:0] v;
    v = '0;
    v[code] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/evtrig_channel.sv
module evtrig_channel
  import evtrig_pkg::*;
#(
  parameter int DLY_W = 16,
  parameter int WID_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 evt_valid,
  input  logic [EV_CODE_W-1:0] evt_code,
  input  logic [EV_CODE_W-1:0] match_code,
  input  logic [DLY_W-1:0]     delay,
  input  logic [WID_W-1:0]     width,
  output logic                 trig
);
  localparam int CNT_W = (DLY_W > WID_W) ? DLY_W : WID_W;

  ch_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic             cnt_done;

  // Count value loaded for an interval of n cycles (n >= 1).
  function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] n);
    return n - CNT_W'(1);
  endfunction

  assign hit      = enable && evt_valid && (evt_code == match_code);
  assign cnt_done = (cnt == '0);
  assign trig     = (state == CH_PULSE);

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state <= CH_IDLE;
      cnt   <= '0;
    end else if (hit) begin
      if (delay != '0) begin
        state <= CH_DELAY;
        cnt   <= load_of(CNT_W'(delay));
      end else if (width != '0) begin
        state <= CH_PULSE;
        cnt   <= load_of(CNT_W'(width));
      end else begin
        state <= CH_IDLE;
        cnt   <= '0;
      end
    end else begin
      case (state)
        CH_DELAY: begin
          if (!cnt_done) begin
            cnt <= cnt - CNT_W'(1);
          end else if (width != '0) begin
            state <= CH_PULSE;
            cnt   <= load_of(CNT_W'(width));
          end else begin
            state <= CH_IDLE;
          end
        end
        CH_PULSE: begin
          if (cnt_done) state <= CH_IDLE;
          else          cnt   <= cnt - CNT_W'(1);
        end
        default: state <= CH_IDLE;
      endcase
    end
  end

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !trig);
  assert_restart_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && delay != '0) |=> (state == CH_DELAY && !trig));
  assert_zero_delay_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && delay == '0 && width != '0) |=> trig);
  assert_no_width_no_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (width == '0 && !trig && $stable(width)) |=> !trig);
endmodule

// File: rtl/evtrig_phase.sv
module evtrig_phase
  import evtrig_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic [EV_CODE_W-1:0] evt_code,
  input  logic [EV_CODE_W-1:0] sync_code,
  output logic [DIV_W-1:0]     count,
  output logic                 div_clk
);
  logic sync_hit;

  function automatic logic [DIV_W-1:0] div_next(input logic [DIV_W-1:0] c, input logic sync);
    return sync ? '0 : c + DIV_W'(1);
  endfunction

  assign sync_hit = evt_valid && (evt_code == sync_code);
  assign div_clk  = count[DIV_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= div_next(count, sync_hit);
  end

  assert_sync_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_hit |=> (count == '0));
  assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_hit && count == '1) |=> (count == '0));
endmodule

// File: rtl/evtrig_irq.sv
module evtrig_irq
  import evtrig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 evt_valid,
  input  logic [EV_CODE_W-1:0] evt_code,
  input  logic [EV_NCODE-1:0]  mask,
  input  logic [EV_NCODE-1:0]  clr,
  output logic [EV_NCODE-1:0]  flags,
  output logic                 req
);
  logic [EV_NCODE-1:0] set_vec;

  assign set_vec = evt_valid ? (mask & code_onehot(evt_code)) : '0;
  assign req     = |flags;

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | set_vec;
  end

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && mask[evt_code]) |=> (flags[$past(evt_code)] && req));
  assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && clr == '1) |=> !req);
endmodule

// File: rtl/evtrig_gen.sv
module evtrig_gen
  import evtrig_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int DLY_W = 16,
  parameter int WID_W = 8,
  parameter int DIV_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     evt_valid,
  input  logic [EV_CODE_W-1:0]     evt_code,
  input  logic [NCH-1:0]           ch_enable,
  input  logic [NCH*EV_CODE_W-1:0] ch_code,
  input  logic [NCH*DLY_W-1:0]     ch_delay,
  input  logic [NCH*WID_W-1:0]     ch_width,
  input  logic [EV_CODE_W-1:0]     sync_code,
  input  logic [EV_NCODE-1:0]      irq_mask,
  input  logic [EV_NCODE-1:0]      irq_clr,
  output logic [NCH-1:0]           trig_out,
  output logic [DIV_W-1:0]         div_count,
  output logic                     div_clk,
  output logic [EV_NCODE-1:0]      irq_flags,
  output logic                     irq_req
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    evtrig_channel #(.DLY_W(DLY_W), .WID_W(WID_W)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (ch_enable[k]),
      .evt_valid  (evt_valid),
      .evt_code   (evt_code),
      .match_code (ch_code[k*EV_CODE_W +: EV_CODE_W]),
      .delay      (ch_delay[k*DLY_W +: DLY_W]),
      .width      (ch_width[k*WID_W +: WID_W]),
      .trig       (trig_out[k])
    );
  end

  evtrig_phase #(.DIV_W(DIV_W)) u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .sync_code (sync_code),
    .count     (div_count),
    .div_clk   (div_clk)
  );

  evtrig_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .mask      (irq_mask),
    .clr       (irq_clr),
    .flags     (irq_flags),
    .req       (irq_req)
  );

  assert_reset_quiet_R11: assert property (@(posedge clk)
    !rst_n |=> (trig_out == '0 && div_count == '0 && !irq_req));
endmodule

// File: tb/evtrig_gen_test.sv
module evtrig_gen_test;
  localparam int CLK_P = 10;
  localparam int NCH = 8, DLY_W = 16, WID_W = 8, DIV_W = 4, NC = 256;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0;
  logic [7:0] evt_code = '0, sync_code = '0;
  logic [NCH-1:0] ch_enable = '0;
  logic [NCH*8-1:0] ch_code;
  logic [NCH*DLY_W-1:0] ch_delay;
  logic [NCH*WID_W-1:0] ch_width;
  logic [NC-1:0] irq_mask = '0, irq_clr = '0;
  logic [NCH-1:0] trig_out;
  logic [DIV_W-1:0] div_count;
  logic div_clk;
  logic [NC-1:0] irq_flags;
  logic irq_req;

  int cc[NCH], dd[NCH], ww[NCH];
  int mlast[NCH];
  bit mval[NCH], remat[NCH];
  int n = 0, checks = 0, errors = 0;
  logic [DIV_W-1:0] exp_cnt = '0;
  logic [NC-1:0] exp_flags = '0;
  bit sync_now;

  always #(CLK_P/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      ch_code[k*8 +: 8]        = 8'(cc[k]);
      ch_delay[k*DLY_W +: DLY_W] = DLY_W'(dd[k]);
      ch_width[k*WID_W +: WID_W] = WID_W'(ww[k]);
    end
  end

  evtrig_gen #(.NCH(NCH), .DLY_W(DLY_W), .WID_W(WID_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .ch_enable(ch_enable), .ch_code(ch_code), .ch_delay(ch_delay), .ch_width(ch_width),
    .sync_code(sync_code), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .trig_out(trig_out), .div_count(div_count), .div_clk(div_clk),
    .irq_flags(irq_flags), .irq_req(irq_req));

  // Expected trigger level t edges after the match, from R2.
  function automatic bit exp_trig(int t, int d, int w);
    return (t >= d) && (t < d + w);
  endfunction

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, n);
    end
  endtask

  task automatic step(bit v, logic [7:0] code, logic [NC-1:0] clr);
    evt_valid = v; evt_code = code; irq_clr = clr;
    @(posedge clk); n++;
    @(negedge clk);
    // model update for the edge just taken
    for (int k = 0; k < NCH; k++) begin
      if (!ch_enable[k]) begin
        mval[k] = 0; remat[k] = 0;
      end else if (v && code == 8'(cc[k])) begin
        remat[k] = mval[k] && (n - mlast[k] < dd[k] + ww[k]);
        mval[k] = 1; mlast[k] = n;
      end
    end
    sync_now = v && (code == sync_code);
    exp_cnt = sync_now ? '0 : exp_cnt + 1'b1;
    exp_flags = exp_flags & ~clr;
    if (v && irq_mask[code]) exp_flags[code] = 1'b1;
    // checks
    for (int k = 0; k < NCH; k++) begin
      bit e;
      e = mval[k] && exp_trig(n - mlast[k], dd[k], ww[k]);
      if (!ch_enable[k])      chk("R5", 256'(trig_out[k]), 256'(1'b0));
      else if (!mval[k])      chk("R1", 256'(trig_out[k]), 256'(1'b0));
      else if (ww[k] == 0)    chk("R3", 256'(trig_out[k]), 256'(1'b0));
      else if (remat[k])      chk("R4", 256'(trig_out[k]), 256'(e));
      else                    chk("R2", 256'(trig_out[k]), 256'(e));
    end
    if (sync_now) chk("R7", 256'(div_count), 256'(exp_cnt));
    else          chk("R6", 256'({div_clk, div_count}), 256'({exp_cnt[DIV_W-1], exp_cnt}));
    if (clr != '0) chk("R9", irq_flags, exp_flags);
    else           chk("R8", irq_flags, exp_flags);
    chk("R10", 256'(irq_req), 256'(|exp_flags));
  endtask

  function automatic logic [NC-1:0] rand_vec256();
    logic [NC-1:0] r;
    for (int i = 0; i < NC/32; i++) r[i*32 +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NCH; k++) begin cc[k] = 0; dd[k] = 0; ww[k] = 0; mval[k] = 0; remat[k] = 0; mlast[k] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11", 256'({trig_out, div_count, irq_req}), 256'(0));
    chk("R11", irq_flags, '0);
    rst_n = 1'b1;

    // directed corners: zero delay, rematch restart, zero width, disable abort
    cc[0] = 5; dd[0] = 0; ww[0] = 1;
    cc[1] = 5; dd[1] = 3; ww[1] = 2;
    cc[2] = 5; dd[2] = 2; ww[2] = 0;
    cc[3] = 6; dd[3] = 4; ww[3] = 3;
    sync_code = 8'd9; irq_mask = '0; irq_mask[5] = 1'b1; irq_mask[6] = 1'b1;
    ch_enable = 8'h0F;
    step(1, 8'd5, '0);
    step(0, 8'd0, '0);
    step(1, 8'd5, '0);              // restart channel 1 mid delay
    for (int i = 0; i < 6; i++) step(0, 8'd0, '0);
    step(1, 8'd6, '0);
    step(0, 8'd0, '0);
    ch_enable[3] = 1'b0;            // abort channel 3 during its delay
    for (int i = 0; i < 6; i++) step(0, 8'd0, '0);
    step(1, 8'd9, '0);              // start-of-cycle
    step(1, 8'd5, {NC{1'b0}} | (NC'(1) << 5)); // set wins over clear
    step(0, 8'd0, '1);              // clear everything

    // constrained random phases
    for (int p = 0; p < 6; p++) begin
      ch_enable = '0;
      step(0, 8'd0, '0);
      for (int k = 0; k < NCH; k++) begin
        cc[k] = $urandom_range(11);
        dd[k] = ($urandom_range(3) == 0) ? 0 : $urandom_range(20);
        ww[k] = $urandom_range(6);
      end
      sync_code = 8'($urandom_range(11));
      irq_mask = rand_vec256();
      ch_enable = 8'($urandom) | 8'h81;
      for (int i = 0; i < 400; i++) begin
        logic [NC-1:0] c;
        c = '0;
        if ($urandom_range(15) == 0) c = rand_vec256();
        if (i == 200) ch_enable[$urandom_range(NCH-1)] ^= 1'b1;
        step($urandom_range(9) < 3, 8'($urandom_range(11)), c);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule